// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads translation descriptors from a page table in memory that has two levels. A request carries the virtual address and the base of the first-level table. The walker then issues one read for the first-level entry. That entry either ends the walk or names a second-level coarse table, in which case a second read follows.

The walk ends with a single-cycle completion pulse. The pulse carries the physical address, a page-size code and a fault flag. Four granules are supported: 16MB, 1MB, 64KB and 4KB.

Memory is reached through a read port that allows one read in flight at a time. The port has a request valid/ready handshake and a read-data valid strobe. The memory may stall both the request and the data for any number of cycles.

Top module: `pt_walker`

## Requirements
- R1: After reset `reqReady` is 1, and both `memReqValid` and `doneValid` are 0.
- R2: The first read goes to address {ttb[31:14], va[31:20], 2'b00}.
- R3: A first-level entry whose low two bits are 00 or 11 ends the walk with `doneFault`=1. The result has `donePa`=0 and `doneSize`=0, and no second read is made.
- R4: A first-level entry with low bits 10 and bit 18 equal to 0 is a 1MB block. The result is `donePa`={d[31:20], va[19:0]} with `doneSize`=2.
- R5: A first-level entry with low bits 10 and bit 18 equal to 1 is a 16MB block. The result is `donePa`={d[31:24], va[23:0]} with `doneSize`=3.
- R6: A first-level entry with low bits 01 names a coarse table. The second read goes to {d[31:10], va[19:12], 2'b00}.
- R7: A second-level entry whose low bits are 00 gives a fault, with `donePa`=0 and `doneSize`=0.
- R8: A second-level entry with low bits 01 maps 64KB. The result is `donePa`={d[31:16], va[15:0]} with `doneSize`=1.
- R9: A second-level entry with low bits 10 or 11 maps 4KB. The result is `donePa`={d[31:12], va[11:0]} with `doneSize`=0.
- R10: `reqReady` is high only while idle. A request offered during a walk is ignored. `doneValid` lasts exactly one cycle.
- R11: `memReqValid` holds with a stable `memAddr` until `memReqReady`. After acceptance it stays low until read data returns, however long that takes.
- R12: A walk that ends at the first level performs exactly one read. A walk through a coarse table performs exactly two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker idle and accepting |
| reqVa | input | 32 | Virtual address |
| reqTtb | input | 32 | First-level table base |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memAddr | output | 32 | Descriptor read address |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 32 | Descriptor data |
| doneValid | output | 1 | One-cycle completion pulse |
| donePa | output | 32 | Physical address |
| doneSize | output | 2 | 0=4KB, 1=64KB, 2=1MB, 3=16MB |
| doneFault | output | 1 | Translation fault |

## Verification
A corrupted walk state shows at the memory port within one cycle. It appears either as a read to the wrong address, or as a read that is missing or extra compared with the descriptor type. A stale captured address, or a wrong descriptor decode, only becomes visible on the completion pulse that ends the walk, as a wrong physical address, size or fault flag. The bench therefore compares every read address and every read count with values it derives itself, across all descriptor type codes and several stall patterns. It also compares every completion with its own expected values.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int ADDR_W = 32;
  localparam int DESC_HI_LO = 10;
  localparam int DESC_HI_W = ADDR_W - DESC_HI_LO;
  localparam int TTB_LO = 14;
  localparam int TTB_W = ADDR_W - TTB_LO;

  typedef enum logic [1:0] {SZ_4K = 2'd0, SZ_64K = 2'd1, SZ_1M = 2'd2, SZ_16M = 2'd3} pageSize_e;
  typedef enum logic [1:0] {ST_IDLE, ST_L1, ST_L2, ST_DONE} walkState_e;
  typedef enum logic [1:0] {K_FAULT, K_TABLE, K_BLOCK} l1Kind_e;

  typedef struct packed {
    logic loadReq;
    logic useL2;
    logic saveL1;
    logic finishL1;
    logic finishL2;
  } walkStrobe_t;
endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReqReady,
  input  logic        memRdValid,
  input  l1Kind_e     l1Kind,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        doneValid,
  output walkStrobe_t strobe
);
  walkState_e state, stateNext;
  logic sentQ;
  logic rdTaken;

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = ((state == ST_L1) || (state == ST_L2)) && !sentQ;
  assign doneValid   = (state == ST_DONE);
  assign rdTaken     = sentQ && memRdValid;

  always_comb begin
    strobe          = '0;
    strobe.loadReq  = (state == ST_IDLE) && reqValid;
    strobe.useL2    = (state == ST_L2);
    strobe.saveL1   = (state == ST_L1) && rdTaken && (l1Kind == K_TABLE);
    strobe.finishL1 = (state == ST_L1) && rdTaken && (l1Kind != K_TABLE);
    strobe.finishL2 = (state == ST_L2) && rdTaken;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid) stateNext = ST_L1;
      ST_L1:   if (rdTaken) stateNext = (l1Kind == K_TABLE) ? ST_L2 : ST_DONE;
      ST_L2:   if (rdTaken) stateNext = ST_DONE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      sentQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (rdTaken) sentQ <= 1'b0;
      else if (memReqValid && memReqReady) sentQ <= 1'b1;
    end
  end
endmodule

// File: rtl/walk_datapath.sv
module walk_datapath
  import walk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  walkStrobe_t          strobe,
  input  logic [ADDR_W-1:0]    reqVa,
  input  logic [TTB_W-1:0]     reqTtbHi,
  input  logic [DESC_HI_W-1:0] descHi,
  input  logic [1:0]           descType,
  output logic [ADDR_W-1:0]    memAddr,
  output l1Kind_e              l1Kind,
  output logic [ADDR_W-1:0]    donePa,
  output logic [1:0]           doneSize,
  output logic                 doneFault
);
  logic [ADDR_W-1:0]    vaQ;
  logic [TTB_W-1:0]     ttbQ;
  logic [DESC_HI_W-1:0] tableQ;
  logic [ADDR_W-1:0]    desc;
  logic [ADDR_W-1:0]    paNext;
  pageSize_e            sizeNext;
  logic                 faultNext;

  assign desc = {descHi, 8'h00, descType};

  assign memAddr = strobe.useL2 ? {tableQ, vaQ[19:12], 2'b00}
                                : {ttbQ, vaQ[31:20], 2'b00};

  always_comb begin
    unique case (descType)
      2'b01:   l1Kind = K_TABLE;
      2'b10:   l1Kind = K_BLOCK;
      default: l1Kind = K_FAULT;
    endcase
  end

  always_comb begin
    paNext    = '0;
    sizeNext  = SZ_4K;
    faultNext = 1'b0;
    if (strobe.finishL2) begin
      unique case (descType)
        2'b00:   faultNext = 1'b1;
        2'b01: begin paNext = {desc[31:16], vaQ[15:0]}; sizeNext = SZ_64K; end
        default: begin paNext = {desc[31:12], vaQ[11:0]}; sizeNext = SZ_4K; end
      endcase
    end else if (l1Kind == K_BLOCK) begin
      if (desc[18]) begin paNext = {desc[31:24], vaQ[23:0]}; sizeNext = SZ_16M; end
      else begin paNext = {desc[31:20], vaQ[19:0]}; sizeNext = SZ_1M; end
    end else begin
      faultNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ       <= '0;
      ttbQ      <= '0;
      tableQ    <= '0;
      donePa    <= '0;
      doneSize  <= '0;
      doneFault <= 1'b0;
    end else begin
      if (strobe.loadReq) begin
        vaQ  <= reqVa;
        ttbQ <= reqTtbHi;
      end
      if (strobe.saveL1) tableQ <= descHi;
      if (strobe.finishL1 || strobe.finishL2) begin
        donePa    <= paNext;
        doneSize  <= sizeNext;
        doneFault <= faultNext;
      end
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import walk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVa,
  input  logic [ADDR_W-1:0] reqTtb,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRdValid,
  input  logic [ADDR_W-1:0] memRdData,
  output logic              doneValid,
  output logic [ADDR_W-1:0] donePa,
  output logic [1:0]        doneSize,
  output logic              doneFault
);
  walkStrobe_t strobe;
  l1Kind_e     l1Kind;

  walk_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memReqReady(memReqReady),
    .memRdValid(memRdValid), .l1Kind(l1Kind), .reqReady(reqReady),
    .memReqValid(memReqValid), .doneValid(doneValid), .strobe(strobe)
  );

  walk_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVa(reqVa),
    .reqTtbHi(reqTtb[ADDR_W-1:TTB_LO]), .descHi(memRdData[ADDR_W-1:DESC_HI_LO]),
    .descType(memRdData[1:0]), .memAddr(memAddr), .l1Kind(l1Kind),
    .donePa(donePa), .doneSize(doneSize), .doneFault(doneFault)
  );
endmodule

// File: rtl/walk_checker.sv
module walk_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic [31:0] memAddr,
  input logic        doneValid,
  input logic [31:0] donePa,
  input logic [1:0]  doneSize,
  input logic        doneFault
);
  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memAddr));
  p_single_outstanding_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqReady |=> !memReqValid);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);
  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqReady, memReqValid, doneValid}));
  p_fault_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneFault |-> donePa == 32'h0 && doneSize == 2'd0);
endmodule

bind pt_walker walk_checker i_walk_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memAddr(memAddr),
  .doneValid(doneValid), .donePa(donePa), .doneSize(doneSize), .doneFault(doneFault)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [31:0] reqVa = '0;
  logic [31:0] reqTtb = '0;
  logic memReqValid;
  logic memReqReady = 1'b0;
  logic [31:0] memAddr;
  logic memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic doneValid;
  logic [31:0] donePa;
  logic [1:0] doneSize;
  logic doneFault;

  int checks = 0;
  int errors = 0;
  bit timedOut = 1'b0;

  always #4 clk = ~clk;

  pt_walker i_pt_walker (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkDesc(input logic [31:0] seed, input logic [1:0] t, input bit b18);
    logic [31:0] d;
    d = seed * 32'h9E3779B1 + 32'h7F4A7C15;
    d[18] = b18;
    d[1:0] = t;
    return d;
  endfunction

  task automatic walk(input logic [31:0] va, input logic [31:0] ttb, input logic [31:0] l1d,
                      input logic [31:0] l2d, input int stall, input int lat, input bit busyPoke);
    logic [31:0] expPa, expL1, expL2;
    logic [1:0] expSize;
    bit expFault, expTwo;
    int reads;
    bit seen;
    expL1 = {ttb[31:14], va[31:20], 2'b00};
    expL2 = {l1d[31:10], va[19:12], 2'b00};
    expTwo = 1'b0; expFault = 1'b0; expPa = '0; expSize = 2'd0;
    if (l1d[1:0] == 2'b10) begin
      if (l1d[18]) begin expPa = {l1d[31:24], va[23:0]}; expSize = 2'd3; end
      else begin expPa = {l1d[31:20], va[19:0]}; expSize = 2'd2; end
    end else if (l1d[1:0] == 2'b01) begin
      expTwo = 1'b1;
      if (l2d[1:0] == 2'b00) expFault = 1'b1;
      else if (l2d[1:0] == 2'b01) begin expPa = {l2d[31:16], va[15:0]}; expSize = 2'd1; end
      else begin expPa = {l2d[31:12], va[11:0]}; expSize = 2'd0; end
    end else expFault = 1'b1;

    @(negedge clk);
    reqValid = 1'b1; reqVa = va; reqTtb = ttb;
    @(negedge clk);
    check(!reqReady, "R10 busy after accept", {31'd0, reqReady}, 32'd0);
    if (busyPoke) begin reqVa = ~va; reqTtb = ~ttb; end
    else reqValid = 1'b0;
    reads = 0; seen = 1'b0;
    for (int it = 0; it < 400 && !seen; it++) begin
      if (doneValid) begin
        seen = 1'b1;
        reqValid = 1'b0;
        check(doneFault == expFault, "R3/R7 fault flag", {31'd0, doneFault}, {31'd0, expFault});
        check(donePa == expPa, "R4/R5/R8/R9 physical address", donePa, expPa);
        check(doneSize == expSize, "R4/R5/R8/R9 size code", {30'd0, doneSize}, {30'd0, expSize});
        check(reads == (expTwo ? 2 : 1), "R12 read count", reads, expTwo ? 2 : 1);
        @(negedge clk);
        check(!doneValid, "R10 one-cycle done", {31'd0, doneValid}, 32'd0);
      end else if (memReqValid) begin
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          check(memReqValid, "R11 request held", {31'd0, memReqValid}, 32'd1);
        end
        check(memAddr == (reads == 0 ? expL1 : expL2), reads == 0 ? "R2 first read address" : "R6 second read address",
              memAddr, reads == 0 ? expL1 : expL2);
        memReqReady = 1'b1;
        @(negedge clk);
        memReqReady = 1'b0;
        for (int l = 0; l < lat; l++) begin
          check(!memReqValid, "R11 single outstanding", {31'd0, memReqValid}, 32'd0);
          @(negedge clk);
        end
        memRdValid = 1'b1;
        memRdData = (reads == 0) ? l1d : l2d;
        reads++;
        @(negedge clk);
        memRdValid = 1'b0;
        memRdData = 32'hDEAD_BEEF;
      end else begin
        @(negedge clk);
      end
    end
    if (!seen) check(1'b0, "R10 walk completes", 32'd0, 32'd1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    timedOut = 1'b1;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(reqReady && !memReqValid && !doneValid, "R1 reset state",
          {29'd0, reqReady, memReqValid, doneValid}, 32'd4);
    @(negedge clk);
    rstN = 1'b1;
    n = 0;
    for (int v = 0; v < 5; v++) begin
      logic [31:0] va, ttb;
      va = 32'h1357_9BDF * (v + 1) ^ 32'hA5A5_0F0F;
      ttb = 32'hC000_4000 + v * 32'h0001_C000;
      for (int t1 = 0; t1 < 4; t1++)
        for (int b = 0; b < 2; b++)
          for (int t2 = 0; t2 < 4; t2++) begin
            walk(va, ttb, mkDesc(va + t1, t1[1:0], b[0]), mkDesc(~va + t2, t2[1:0], b[0]),
                 n % 3, (n / 3) % 4, (n % 5) == 2);
            n++;
          end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule